// File: doc/BRIEF.md
# Memory Bit Set/Clear/Invert Engine

This block changes a single bit inside one byte of memory through a read-modify-write sequence. A caller presents an operation code, a byte address and a full-width register value whose low bits pick the bit. The engine reads the byte over a one-byte request/response memory port and tests the chosen bit. It then forces the bit to one, forces it to zero or inverts it, and writes the byte back to the same address.

The result of the bit test is reported in a flag vector. The zero flag in that vector reflects the bit as it was read, before the change. Every other flag is copied from the caller's flag input, taken when the operation is accepted. A one-cycle completion pulse marks the end of each operation. One operation is in flight at a time. The illegal operation code is dropped without touching memory.

Top module: `bitop_rmw`

## Requirements
- R1: After reset `done` is 0, `mem_req` is 0 and `flags_out` is all zeros.
- R2: The bit position is `index[2:0]` (the index modulo 8); all higher index bits have no effect on which bit is changed or tested.
- R3: Operation encodings on `op`: 2'b00 forces the selected bit to 1, 2'b01 forces it to 0, 2'b10 inverts it; all other bits of the byte are written back as read.
- R4: At completion `flags_out[0]` is the zero flag: 1 when the selected bit was 0 in the byte as read, 0 when it was 1.
- R5: At completion `flags_out[3:1]` equal `flags_in[3:1]` as sampled when the operation was accepted, and `flags_out` changes only in the cycle where `done` is 1.
- R6: Each accepted operation makes exactly one read (`mem_we`=0) and then exactly one write (`mem_we`=1), both to the accepted address, and the write is made even when the byte is unchanged.
- R7: `op` = 2'b11 with `start` is ignored: no memory request, no `done`, and `flags_out` keeps its value.
- R8: `start` is accepted only while the engine is idle; `start`, `addr` or `index` presented during an operation, including its `done` cycle, have no effect.
- R9: `done` is high for exactly one cycle, in the cycle after the write response (`mem_rvalid`), and once per accepted operation.
- R10: While `mem_req` is high and `mem_gnt` is low, the request, `mem_we`, `mem_addr` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation code (00 set, 01 clear, 10 invert, 11 illegal) |
| addr | input | AW (8) | Byte address to modify |
| index | input | IW (32) | Register value; low three bits select the bit |
| flags_in | input | FW (4) | Current flag vector from the caller |
| flags_out | output | FW (4) | Flag vector after the last completed operation; bit 0 is zero |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW (8) | Memory byte address |
| mem_wdata | output | BW (8) | Byte to be written |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Response: read data valid, or write completed |
| mem_rdata | input | BW (8) | Read data byte |

## Verification
A new request and the completion pulse can share a cycle: a caller that keeps `start` high through an operation presents it again in the `done` cycle. That request must be dropped, because the engine is not idle then. The bench provokes this by holding `start` high from launch until one cycle after `done`. It also moves `addr` to a different byte once the operation has been accepted. It then judges the outcome at the ports: the memory must see exactly one read and one write, both at the original address, and the neighbouring byte must be untouched. A behavioural memory with a variable grant delay is checked against the expected address and write data on every clock it grants a request.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_SET = 2'b00,
        OP_CLR = 2'b01,
        OP_INV = 2'b10,
        OP_BAD = 2'b11
    } bitop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_DONE
    } state_e;

endpackage

// File: rtl/bitop_mask.sv
// One-hot mask from the low bits of a register-wide index.
module bitop_mask #(
    parameter int IW = 32,
    parameter int BW = 8
) (
    input  logic [IW-1:0] index,
    output logic [BW-1:0] mask
);
    localparam int SW = $clog2(BW);

    logic [SW-1:0] pos;
    assign pos = index[SW-1:0];

    for (genvar i = 0; i < BW; i++) begin : g_bit
        assign mask[i] = (pos == SW'(i));
    end

endmodule

// File: rtl/bitop_alter.sv
// Applies the operation to a byte and reports whether the masked bit was clear.
module bitop_alter
    import bitop_pkg::*;
#(
    parameter int BW = 8
) (
    input  bitop_e        op,
    input  logic [BW-1:0] old_byte,
    input  logic [BW-1:0] mask,
    output logic [BW-1:0] new_byte,
    output logic          was_zero
);
    for (genvar i = 0; i < BW; i++) begin : g_lane
        assign new_byte[i] = (op == OP_SET) ? (old_byte[i] | mask[i])  :
                             (op == OP_CLR) ? (old_byte[i] & ~mask[i]) :
                             (op == OP_INV) ? (old_byte[i] ^ mask[i])  :
                                              old_byte[i];
    end

    assign was_zero = ((old_byte & mask) == '0);

endmodule

// File: rtl/bitop_rmw.sv
module bitop_rmw
    import bitop_pkg::*;
#(
    parameter int AW   = 8,
    parameter int IW   = 32,
    parameter int BW   = 8,
    parameter int FW   = 4,
    parameter int ZBIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [IW-1:0] index,
    input  logic [FW-1:0] flags_in,
    output logic [FW-1:0] flags_out,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [BW-1:0] mem_rdata
);

    typedef struct packed {
        state_e        state;
        bitop_e        op;
        logic [AW-1:0] addr;
        logic [BW-1:0] mask;
        logic [BW-1:0] wdata;
        logic          zero;
        logic [FW-1:0] flags_cap;
        logic [FW-1:0] flags;
    } regs_t;

    regs_t r_d, r_q;

    logic [BW-1:0] mask_w;
    logic [BW-1:0] new_w;
    logic          was_zero_w;

    bitop_mask #(.IW(IW), .BW(BW)) u_mask (
        .index (index),
        .mask  (mask_w)
    );

    bitop_alter #(.BW(BW)) u_alter (
        .op       (r_q.op),
        .old_byte (mem_rdata),
        .mask     (r_q.mask),
        .new_byte (new_w),
        .was_zero (was_zero_w)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start && (bitop_e'(op) != OP_BAD)) begin
                    r_d.state     = ST_RD_REQ;
                    r_d.op        = bitop_e'(op);
                    r_d.addr      = addr;
                    r_d.mask      = mask_w;
                    r_d.flags_cap = flags_in;
                end
            end
            ST_RD_REQ: begin
                if (mem_gnt) r_d.state = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    r_d.state = ST_WR_REQ;
                    r_d.wdata = new_w;
                    r_d.zero  = was_zero_w;
                end
            end
            ST_WR_REQ: begin
                if (mem_gnt) r_d.state = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (mem_rvalid) begin
                    r_d.state       = ST_DONE;
                    r_d.flags       = r_q.flags_cap;
                    r_d.flags[ZBIT] = r_q.zero;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, op: OP_SET, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = (r_q.state == ST_RD_REQ) || (r_q.state == ST_WR_REQ);
    assign mem_we    = (r_q.state == ST_WR_REQ);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign done      = (r_q.state == ST_DONE);
    assign flags_out = r_q.flags;

endmodule

// File: rtl/bitop_rmw_chk.sv
module bitop_rmw_chk #(
    parameter int AW = 8,
    parameter int BW = 8,
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idle,
    input logic          start,
    input logic [1:0]    op,
    input logic [AW-1:0] addr,
    input logic [FW-1:0] flags_out,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [BW-1:0] mem_wdata,
    input logic          mem_gnt
);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    p_bad_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && op == 2'b11) |=> (idle && !mem_req));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && op != 2'b11) |=> (mem_req && !mem_we && mem_addr == $past(addr)));

    p_flags_only_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags_out) |-> done);

endmodule

bind bitop_rmw bitop_rmw_chk #(.AW(AW), .BW(BW), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (r_q.state == bitop_pkg::ST_IDLE),
    .start     (start),
    .op        (op),
    .addr      (addr),
    .flags_out (flags_out),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt)
);

// File: tb/bitop_rmw_test.sv
`timescale 1ns/1ps
module bitop_rmw_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [7:0]  addr = '0;
    logic [31:0] index = '0;
    logic [3:0]  flags_in = '0;
    logic [3:0]  flags_out;
    logic        done;
    logic        mem_req;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #2 clk = ~clk;

    bitop_rmw uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
        .index(index), .flags_in(flags_in), .flags_out(flags_out), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;
    int nrd = 0;
    int nwr = 0;
    int gnt_lat = 0;
    int wait_cnt = 0;
    bit resp_pend = 0;
    logic [7:0] resp_data = '0;
    logic [7:0] exp_addr = '0;
    logic [7:0] exp_wdata = '0;
    logic [7:0] mem [0:255];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural memory: grant after gnt_lat waiting cycles, respond one cycle later.
    always @(negedge clk) begin
        mem_gnt = 1'b0;
        mem_rvalid = 1'b0;
        if (resp_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = resp_data;
            resp_pend  = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= gnt_lat) begin
                mem_gnt   = 1'b1;
                wait_cnt  = 0;
                resp_pend = 1'b1;
                chk(mem_addr == exp_addr, "R6 access address", mem_addr, exp_addr);
                if (mem_we) begin
                    chk(mem_wdata == exp_wdata, "R3 write data", mem_wdata, exp_wdata);
                    mem[mem_addr] = mem_wdata;
                    nwr++;
                end else begin
                    resp_data = mem[mem_addr];
                    nrd++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 50000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [31:0] idx,
                          input logic [3:0] fl, input bit hold);
        logic [7:0] old_b, m, new_b;
        logic [3:0] exp_fl;
        int rd0, wr0;
        logic [7:0] nb_before;
        old_b = mem[a];
        m = 8'h01 << idx[2:0];
        case (o)
            2'b00:   new_b = old_b | m;
            2'b01:   new_b = old_b & ~m;
            default: new_b = old_b ^ m;
        endcase
        exp_fl = {fl[3:1], ((old_b & m) == 8'h00)};
        exp_addr = a;
        exp_wdata = new_b;
        rd0 = nrd;
        wr0 = nwr;
        nb_before = mem[a + 8'd1];
        @(negedge clk);
        start = 1'b1; op = o; addr = a; index = idx; flags_in = fl;
        @(negedge clk);
        if (hold) begin
            addr = a + 8'd1;
            index = ~idx;
            flags_in = ~fl;
        end else begin
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(flags_out[0] == exp_fl[0], "R4 zero flag", flags_out, exp_fl);
        chk(flags_out[3:1] == exp_fl[3:1], "R5 other flags", flags_out, exp_fl);
        chk(mem[a] == new_b, "R3 stored byte (R2 index)", mem[a], new_b);
        chk(nrd - rd0 == 1 && nwr - wr0 == 1, "R6 one read one write", (nrd - rd0) * 16 + (nwr - wr0), 32'h11);
        @(negedge clk);
        chk(done == 1'b0, "R9 single cycle done", done, 0);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(done == 1'b0 && !mem_req, "R9 no extra done", {done, mem_req}, 0);
        if (hold) begin
            chk(nrd - rd0 == 1 && nwr - wr0 == 1, "R8 no second op", (nrd - rd0) * 16 + (nwr - wr0), 32'h11);
            chk(mem[a + 8'd1] == nb_before, "R8 neighbour untouched", mem[a + 8'd1], nb_before);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37) ^ 8'h5A;
        mem[8'h10] = 8'h00;
        mem[8'h20] = 8'h5A;
        mem[8'h30] = 8'hEF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", done, 0);
        chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        chk(flags_out == 4'h0, "R1 flags_out", flags_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        gnt_lat = 0;
        run_op(2'b00, 8'h10, 32'd3, 4'b1010, 0);           // R3 set, R4 bit was 0
        run_op(2'b00, 8'h10, 32'd3, 4'b0110, 0);           // R6 unchanged byte still written
        run_op(2'b01, 8'h10, 32'h2B, 4'b1110, 0);          // R2 index 43 selects bit 3
        gnt_lat = 3;
        run_op(2'b10, 8'h20, 32'd7, 4'b0000, 0);           // R3 invert, R10 delayed grant
        run_op(2'b10, 8'h20, 32'hFFFF_FFF9, 4'b0101, 0);   // R2 high bits ignored
        gnt_lat = 1;
        run_op(2'b01, 8'h30, 32'd4, 4'b1001, 0);           // R3 clear on a clear bit

        // R7: illegal op ignored
        begin
            int rd0;
            logic [3:0] fl0;
            rd0 = nrd;
            fl0 = flags_out;
            @(negedge clk);
            start = 1'b1; op = 2'b11; addr = 8'h40; index = 32'd2; flags_in = 4'hF;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (mem_req || done) begin
                    chk(1'b0, "R7 activity on illegal op", {mem_req, done}, 0);
                end
            end
            chk(nrd == rd0, "R7 no memory access", nrd - rd0, 0);
            chk(flags_out == fl0, "R7 flags kept", flags_out, fl0);
        end

        // R8: start held through the op and its done cycle, address moved after accept
        gnt_lat = 2;
        run_op(2'b00, 8'h50, 32'd6, 4'b0010, 1);
        gnt_lat = 0;
        run_op(2'b10, 8'h51, 32'd0, 4'b1100, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule